// File: doc/BRIEF.md
# Carry/Borrow Stepped Digital Phase-Locked Loop

This block recovers a square wave that follows a slow reference input using nothing but one system clock. An exclusive-OR detector compares the reference with the loop's own output and yields a direction bit. That bit chooses which of two independent modulo-K counters advances on each clock. A counter that passes its midpoint emits a single-cycle pulse. A pulse from the up side is a carry and a pulse from the down side is a borrow.

Carries and borrows steer a half-cycle stepper. In a quiet cycle the stepper's toggle output flips once, so it runs at half the clock rate. A carry inserts one extra half cycle and a borrow swallows one. The stepper output is then divided by N to form the recovered clock, which feeds back to the detector. The free-running period is therefore 2N clocks. Each carry shortens the output by one clock and each borrow stretches it by one.

The loop is first order. It settles at the phase where the carry and borrow rates balance the frequency offset. Both the counter rate and the stepper rate come from the same clock.

Top module: `kid_dpll`

## Requirements
- R1: While `rst_n` is low, `out_clk` is low. On the first clock edge after reset is released, `out_clk` goes high.
- R2: The direction bit is registered and equals `ref_in` XOR `out_clk` as sampled on the previous clock edge.
- R3: When the direction bit is 0, only the up counter advances by one (modulo K). When it is 1, only the down counter advances. The other counter holds its value.
- R4: A carry or borrow is a one-cycle pulse on the rising edge of the matching counter's MSB, which gives one pulse per K advances. A carry and a borrow are never active in the same cycle.
- R5: In each cycle the half-cycle phase advances by 2 on a carry, by 0 on a borrow and by 1 otherwise, modulo 2N. The stepper's toggle output flips exactly when the advance is odd.
- R6: The registered output is high while the half-cycle phase is below N. With `ref_in` held low, the output averages one rising edge per 2N clocks, to within one edge over 20 nominal periods.
- R7: With a reference of period 2N+2 or 2N-2 clocks (defaults N=16, K=8), the output locks. Over a 60-period window, its rising-edge count matches the reference's to within one.
- R8: While locked, every high and every low run of `out_clk` lasts between N-N/4-2 and N+N/4+2 clocks.
- R9: After the reference period steps from 2N-2 to 2N+2 clocks, the loop relocks and again matches the reference's edge count to within one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; drives both the counters and the half-cycle stepper |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference square wave, synchronous to `clk` |
| out_clk | output | 1 | Recovered output, the divide-by-N of the stepper stream |

## Verification
The assertions assume that `ref_in` is already synchronous to `clk` and changes only between edges. The bench meets this by driving the reference from the falling clock edge. The lock properties rely on a reference period within 2N plus or minus 2N/K clocks, the range in which a net rate of carries or borrows can absorb the offset. Every reference the bench applies stays inside that range, with a settle time of 150 periods before any window is measured. The reference is held low only for the free-running check. Reset is applied once mid-run while the reference is active, so that the first-cycle behaviour after release is seen from a non-idle state.

// File: rtl/kid_dpll_pkg.sv
package kid_dpll_pkg;

  // half-cycle advance for one clock: carry adds one, borrow removes one
  function automatic int f_step(input logic inc, input logic dec);
    return 1 + int'(inc) - int'(dec);
  endfunction

  // phase advance modulo the number of half cycles per output period
  function automatic int f_adv(input int ph, input int st, input int n_half);
    int s;
    s = ph + st;
    return (s >= n_half) ? s - n_half : s;
  endfunction

  // output level for a given half-cycle phase
  function automatic logic f_high(input int ph, input int n_div);
    return (ph < n_div);
  endfunction

endpackage

// File: rtl/kid_pd.sv
module kid_pd (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb,
  output logic dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir <= 1'b0;
    else        dir <= ref_in ^ fb;
  end
endmodule

// File: rtl/kid_kside.sv
module kid_kside #(
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [KW-1:0] cnt,
  output logic          pulse
);
  logic msb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      msb_d <= 1'b0;
    end else begin
      if (adv) cnt <= cnt + KW'(1);
      msb_d <= cnt[KW-1];
    end
  end

  assign pulse = cnt[KW-1] & ~msb_d;
endmodule

// File: rtl/kid_kcount.sv
module kid_kcount #(
  parameter  int K_MOD = 8,
  localparam int KW    = $clog2(K_MOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir,
  output logic [KW-1:0] up_cnt,
  output logic [KW-1:0] dn_cnt,
  output logic          carry,
  output logic          borrow
);
  logic [1:0][KW-1:0] cnt_arr;
  logic [1:0]         pul;

  // side 0 counts while the detector says "same", side 1 while "different"
  for (genvar g = 0; g < 2; g++) begin : g_side
    logic adv_g;
    assign adv_g = (g == 0) ? ~dir : dir;
    kid_kside #(.KW(KW)) u_side (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (adv_g),
      .cnt  (cnt_arr[g]),
      .pulse(pul[g])
    );
  end

  assign up_cnt = cnt_arr[0];
  assign dn_cnt = cnt_arr[1];
  assign carry  = pul[0];
  assign borrow = pul[1];
endmodule

// File: rtl/kid_idcnt.sv
module kid_idcnt
  import kid_dpll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       dec,
  output logic [1:0] step,
  output logic       idout
);
  assign step = 2'(f_step(inc, dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idout <= 1'b0;
    else if (step[0]) idout <= ~idout;
  end
endmodule

// File: rtl/kid_divn.sv
module kid_divn
  import kid_dpll_pkg::*;
#(
  parameter  int N_DIV = 16,
  localparam int NH    = 2 * N_DIV,
  localparam int HW    = $clog2(NH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    step,
  output logic [HW-1:0] phase,
  output logic          fb
);
  logic [HW-1:0] ph_next;

  assign ph_next = HW'(f_adv(int'(phase), int'(step), NH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      fb    <= 1'b0;
    end else begin
      phase <= ph_next;
      fb    <= f_high(int'(ph_next), N_DIV);
    end
  end
endmodule

// File: rtl/kid_dpll.sv
module kid_dpll #(
  parameter int N_DIV = 16,
  parameter int K_MOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic out_clk
);
  localparam int KW = $clog2(K_MOD);
  localparam int HW = $clog2(2 * N_DIV);

  // named internal events, observed by the bound checker
  logic          w_dir;
  logic [KW-1:0] w_up;
  logic [KW-1:0] w_dn;
  logic          w_inc;
  logic          w_dec;
  logic [1:0]    w_step;
  logic          w_idout;
  logic [HW-1:0] w_phase;
  logic          w_fb;

  kid_pd u_pd (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb(w_fb), .dir(w_dir)
  );

  kid_kcount #(.K_MOD(K_MOD)) u_kc (
    .clk(clk), .rst_n(rst_n), .dir(w_dir),
    .up_cnt(w_up), .dn_cnt(w_dn), .carry(w_inc), .borrow(w_dec)
  );

  kid_idcnt u_id (
    .clk(clk), .rst_n(rst_n), .inc(w_inc), .dec(w_dec),
    .step(w_step), .idout(w_idout)
  );

  kid_divn #(.N_DIV(N_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .step(w_step), .phase(w_phase), .fb(w_fb)
  );

  assign out_clk = w_fb;
endmodule

// File: rtl/kid_dpll_chk.sv
module kid_dpll_chk #(
  parameter  int N_DIV = 16,
  parameter  int K_MOD = 8,
  localparam int KW    = $clog2(K_MOD),
  localparam int HW    = $clog2(2 * N_DIV)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_in,
  input logic          fb,
  input logic          dir,
  input logic [KW-1:0] up_cnt,
  input logic [KW-1:0] dn_cnt,
  input logic          inc,
  input logic          dec,
  input logic [1:0]    step,
  input logic          idout,
  input logic [HW-1:0] phase
);
  localparam logic [KW-1:0] ONE = KW'(1);

  p_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dir == $past(ref_in ^ fb));

  p_up_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dir)) |-> ((up_cnt - $past(up_cnt)) == ONE && dn_cnt == $past(dn_cnt)));

  p_dn_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dir)) |-> ((dn_cnt - $past(dn_cnt)) == ONE && up_cnt == $past(up_cnt)));

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));

  p_carry_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> !inc);

  p_borrow_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> !dec);

  p_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(phase) == ((int'($past(phase)) + int'($past(step))) % (2 * N_DIV)));

  p_idout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((idout != $past(idout)) == $past(step[0])));

  p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fb == (int'(phase) < N_DIV));

  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |-> !fb);
endmodule

bind kid_dpll kid_dpll_chk #(.N_DIV(N_DIV), .K_MOD(K_MOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb(w_fb), .dir(w_dir),
  .up_cnt(w_up), .dn_cnt(w_dn), .inc(w_inc), .dec(w_dec),
  .step(w_step), .idout(w_idout), .phase(w_phase)
);

// File: tb/kid_dpll_test.sv
module kid_dpll_test;
  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int K     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in;
  logic out_clk;

  int checks = 0;
  int errors = 0;
  int ref_per = 0;
  bit run_on = 1'b0;

  typedef struct {
    string tag;
    int    cycles;
    int    exp;
    int    tol;
  } win_t;
  win_t win_q[$];
  int pushed = 0;
  int done   = 0;

  kid_dpll #(.N_DIV(N), .K_MOD(K)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .out_clk(out_clk)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    checks++;
    if (act < exp - tol || act > exp + tol) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (+/-%0d)", tag, act, exp, tol);
    end
  endtask

  // driver side of the scoreboard: queue an expected edge count, wait for the verdict
  task automatic expect_edges(input string tag, input int cycles, input int exp, input int tol);
    win_q.push_back('{tag, cycles, exp, tol});
    pushed++;
    wait (done == pushed);
  endtask

  // reference generator, changes on falling edges
  initial begin
    ref_in = 1'b0;
    forever begin
      if (ref_per == 0) begin
        @(negedge clk);
        ref_in = 1'b0;
      end else begin
        int p;
        p = ref_per;
        for (int i = 0; i < p; i++) begin
          @(negedge clk);
          ref_in = (i < p / 2);
        end
      end
    end
  end

  // monitor side of the scoreboard: count output rising edges per window
  initial begin
    forever begin
      win_t it;
      int edges;
      logic prev;
      wait (win_q.size() > 0);
      it = win_q[0];
      edges = 0;
      prev = out_clk;
      repeat (it.cycles) begin
        @(negedge clk);
        if (out_clk && !prev) edges++;
        prev = out_clk;
      end
      void'(win_q.pop_front());
      chk(it.tag, edges, it.exp, it.tol);
      done++;
    end
  end

  // R8 run-length monitor
  initial begin
    int len;
    bit armed;
    logic prev_o;
    len = 0;
    armed = 1'b0;
    prev_o = 1'b0;
    forever begin
      @(negedge clk);
      if (!run_on) begin
        armed = 1'b0;
        len = 0;
      end else if (out_clk != prev_o) begin
        if (armed) chk("R8 run length", len, N, N / 4 + 2);
        armed = 1'b1;
        len = 1;
      end else begin
        len++;
      end
      prev_o = out_clk;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 low in reset", int'(out_clk), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 high after release", int'(out_clk), 1, 0);

    // free running with the reference held low
    ref_per = 0;
    repeat (200) @(negedge clk);
    expect_edges("R6 centre period (R3 R4 R5 loop)", 20 * 2 * N, 20, 1);

    // slower reference
    ref_per = 2 * N + 2;
    repeat (150 * (2 * N + 2)) @(negedge clk);
    run_on = 1'b1;
    expect_edges("R7 lock slow ref (R2 R3 R4 R5)", 60 * (2 * N + 2), 60, 1);
    run_on = 1'b0;

    // faster reference
    ref_per = 2 * N - 2;
    repeat (150 * (2 * N - 2)) @(negedge clk);
    run_on = 1'b1;
    expect_edges("R7 lock fast ref (R2 R3 R4 R5)", 60 * (2 * N - 2), 60, 1);
    run_on = 1'b0;

    // step back to the slower reference from a locked fast state
    ref_per = 2 * N + 2;
    repeat (150 * (2 * N + 2)) @(negedge clk);
    run_on = 1'b1;
    expect_edges("R9 relock after step", 60 * (2 * N + 2), 60, 1);
    run_on = 1'b0;

    // reset while the reference is active
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 low in mid-run reset", int'(out_clk), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 high after mid-run release", int'(out_clk), 1, 0);
    repeat (150 * (2 * N + 2)) @(negedge clk);
    expect_edges("R7 lock after reset", 60 * (2 * N + 2), 60, 1);

    summary();
  end
endmodule